// File: doc/BRIEF.md
# Translation Cache with Page Permission Checks

This block turns a 32-bit virtual address into a physical address by searching a small, fully associative store of recently used page mappings. Pages are 4096 bytes: the low 12 bits of an address are the page offset and pass through unchanged. Every stored mapping carries a page-present bit and four permission bits: readable, writable, executable and user-accessible.

Each lookup request carries an address, an access kind (data read, data write or instruction fetch) and a privilege flag. The block returns exactly one of four outcomes:

- a translated physical address;
- a miss, which tells the surrounding logic to start a page table walk;
- a page fault;
- a protection fault.

The walker installs mappings through a plain fill port. A flush pin discards every mapping at once.

Requests enter and responses leave through valid/ready handshakes. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. The response appears on the next cycle and stays there, unchanged, until it is taken with `rsp_ready`. `req_ready` is high whenever the response slot is empty or is being emptied in the same cycle. A stalled consumer therefore stops new requests after one outstanding response, and no request or response is ever dropped.

A lookup sees the stored mappings as they were before the clock edge that accepts it. A fill or flush at that same edge does not affect that lookup.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no mapping is held, `rsp_valid` is 0 and `req_ready` is 1, so the first lookup of any address returns a miss.
- R2: On a translation, `rsp_status` is 0 and `rsp_paddr` is the stored frame number shifted left by 12, combined with the request's unchanged low 12 address bits. For example, page 0xA mapped to frame 0xA5 with offset 0x877 gives 0xA5877.
- R3: When no held mapping has the request's page number, `rsp_status` is 1 (miss). For every non-zero status, `rsp_paddr` is 0.
- R4: When the matching mapping has its present bit (`fill_perm[4]`) at 0, `rsp_status` is 2 (page fault). This outcome takes precedence over any protection fault.
- R5: `rsp_status` is 3 (protection fault) in three cases: a write (`req_acc`=1) to a page with `fill_perm[2]` clear; a fetch (`req_acc`=2) from a page with `fill_perm[1]` clear; a read (`req_acc`=0, and code 3 is treated as a read) from a page with `fill_perm[3]` clear.
- R6: A user-mode request (`req_user`=1) to a page whose user bit `fill_perm[0]` is 0 gives `rsp_status` 3, whatever its other permission bits are.
- R7: An accepted request produces `rsp_valid` on the following cycle. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_ready` is low, the pending response holds its status and address unchanged.
- R8: A fill whose page number is already held overwrites that same slot, so a later lookup returns the new frame. Otherwise a fill takes the lowest-numbered free slot.
- R9: When every slot is occupied, fills replace slots in round-robin order. The order starts at slot 0 after reset or flush, so the first mapping installed is the first one replaced.
- R10: A flush empties every slot at one clock edge. A fill presented at the same edge is applied after the flush, so it is the only mapping held afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken by the consumer |
| rsp_status | output | 2 | 0 translated, 1 miss, 2 page fault, 3 protection fault |
| rsp_paddr | output | 32 | Physical address, zero unless translated |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_perm | input | 5 | {present, read, write, execute, user} |
| flush | input | 1 | Discard every held mapping |

## Verification
The bench builds the block with its default parameters: eight slots and 32-bit virtual and physical addresses. With these values, the full page-number width and the full offset range (0x000 to 0xFFF) are exercised. Eight fills are enough to fill the store, so round-robin replacement and its wraparound can be reached with a handful of installs. One vector table covers every combination of access kind, privilege mode and permission bits needed for each outcome, including the case where page-fault and protection-fault causes overlap. Directed sequences cover response back-pressure, overwriting an existing mapping, flushing, and a flush and fill in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_BITS = 12;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] ST_OK     = 2'd0;
  localparam logic [1:0] ST_MISS   = 2'd1;
  localparam logic [1:0] ST_PFAULT = 2'd2;
  localparam logic [1:0] ST_PROT   = 2'd3;

  typedef struct packed {
    logic v;  // page present
    logic r;  // readable
    logic w;  // writable
    logic x;  // executable
    logic u;  // user accessible
  } perm_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VPN_W     = 20,
  parameter int PFN_W     = 20,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [VPN_W-1:0]     wr_vpn,
  input  logic [PFN_W-1:0]     wr_pfn,
  input  perm_t                wr_perm,
  input  logic [VPN_W-1:0]     lk_vpn,
  output logic [N_ENTRIES-1:0] live,
  output logic [N_ENTRIES-1:0] lk_match,
  output logic [N_ENTRIES-1:0] wr_match,
  output logic                 lk_hit,
  output logic [PFN_W-1:0]     lk_pfn,
  output perm_t                lk_perm
);
  logic [VPN_W-1:0]     vpn_q  [N_ENTRIES];
  logic [PFN_W-1:0]     pfn_q  [N_ENTRIES];
  perm_t                perm_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] live_q;

  // Occupancy: flush first, then a same-edge fill marks its slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else begin
      if (flush) live_q <= '0;
      if (wr_en) live_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      pfn_q[wr_idx]  <= wr_pfn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    assign lk_match[i] = live_q[i] && (vpn_q[i] == lk_vpn);
    assign wr_match[i] = live_q[i] && (vpn_q[i] == wr_vpn);
  end

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_pfn  = lk_pfn | pfn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
    end
  end

  assign lk_hit = |lk_match;
  assign live   = live_q;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 fill,
  input  logic [N_ENTRIES-1:0] live,
  input  logic [N_ENTRIES-1:0] dup,
  output logic [IDX_W-1:0]     idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] free_idx;
  logic             use_rr;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (dup[i])   dup_idx  = IDX_W'(i);
      if (!live[i]) free_idx = IDX_W'(i);
    end
  end

  assign use_rr = !flush && (dup == '0) && (&live);

  always_comb begin
    if (flush)        idx = '0;
    else if (|dup)    idx = dup_idx;
    else if (!use_rr) idx = free_idx;
    else              idx = rr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rr_q <= '0;
    end else if (fill && use_rr) begin
      rr_q <= (rr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  logic       hit,
  input  perm_t      perm,
  input  logic [1:0] acc,
  input  logic       user,
  output logic [1:0] status
);
  logic need_ok;

  always_comb begin
    case (acc)
      ACC_WRITE: need_ok = perm.w;
      ACC_FETCH: need_ok = perm.x;
      default:   need_ok = perm.r;
    endcase
  end

  always_comb begin
    if (!hit)                   status = ST_MISS;
    else if (!perm.v)           status = ST_PFAULT;
    else if (user && !perm.u)   status = ST_PROT;
    else if (!need_ok)          status = ST_PROT;
    else                        status = ST_OK;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_status,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [4:0]       fill_perm,
  input  logic             flush
);
  logic [N_ENTRIES-1:0] live_q;
  logic [N_ENTRIES-1:0] hit_vec;
  logic [N_ENTRIES-1:0] fill_dup;
  logic                 hit_any;
  logic [PFN_W-1:0]     hit_pfn;
  perm_t                hit_perm;
  logic [IDX_W-1:0]     fill_idx;
  logic [1:0]           lk_status;
  logic                 accept;
  logic                 rsp_valid_q;
  logic [1:0]           rsp_status_q;
  logic [PA_W-1:0]      rsp_paddr_q;

  tlb_entry_array #(
    .N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (fill_valid),
    .wr_idx   (fill_idx),
    .wr_vpn   (fill_vpn),
    .wr_pfn   (fill_pfn),
    .wr_perm  (perm_t'(fill_perm)),
    .lk_vpn   (req_vaddr[VA_W-1:PAGE_BITS]),
    .live     (live_q),
    .lk_match (hit_vec),
    .wr_match (fill_dup),
    .lk_hit   (hit_any),
    .lk_pfn   (hit_pfn),
    .lk_perm  (hit_perm)
  );

  tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .fill  (fill_valid),
    .live  (live_q),
    .dup   (fill_dup),
    .idx   (fill_idx)
  );

  tlb_perm_check u_check (
    .hit    (hit_any),
    .perm   (hit_perm),
    .acc    (req_acc),
    .user   (req_user),
    .status (lk_status)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= ST_MISS;
      rsp_paddr_q  <= '0;
    end else if (accept) begin
      rsp_valid_q  <= 1'b1;
      rsp_status_q <= lk_status;
      rsp_paddr_q  <= (lk_status == ST_OK)
                      ? {hit_pfn, req_vaddr[PAGE_BITS-1:0]} : '0;
    end else if (rsp_ready) begin
      rsp_valid_q  <= 1'b0;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;
  assign rsp_paddr  = rsp_paddr_q;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [VA_W-1:0]      req_vaddr,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [1:0]           rsp_status,
  input logic [PA_W-1:0]      rsp_paddr,
  input logic                 fill_valid,
  input logic                 flush,
  input logic [N_ENTRIES-1:0] live,
  input logic [N_ENTRIES-1:0] hit_vec
);
  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R7

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=>
      rsp_valid && $stable(rsp_status) && $stable(rsp_paddr)); // R7

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=>
      (rsp_status != 2'd0) || (rsp_paddr[11:0] == $past(req_vaddr[11:0]))); // R2

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_status != 2'd0) |-> rsp_paddr == '0); // R3

  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !fill_valid |=> live == '0); // R10

  AST_FLUSH_FILL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush && fill_valid |=> $countones(live) == 1); // R10
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .N_ENTRIES(N_ENTRIES), .VA_W(VA_W), .PA_W(PA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_vaddr  (req_vaddr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .rsp_paddr  (rsp_paddr),
  .fill_valid (fill_valid),
  .flush      (flush),
  .live       (live_q),
  .hit_vec    (hit_vec)
);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [4:0]  fill_perm = '0;
  logic        flush = 1'b0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  tlb_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .flush(flush)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic        usr;
    logic [1:0]  st;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 15;
  // status: 0 ok, 1 miss, 2 page fault, 3 protection fault
  localparam vec_t VECS [NV] = '{
    '{32'h0000A877, 2'd0, 1'b1, 2'd0, 32'h000A5877},  // R2 worked example
    '{32'h0000AFFF, 2'd1, 1'b0, 2'd0, 32'h000A5FFF},  // R2 top offset
    '{32'h0000A000, 2'd2, 1'b1, 2'd3, 32'h0},         // R5 no execute
    '{32'h00020123, 2'd2, 1'b1, 2'd0, 32'h00300123},  // R2 fetch ok
    '{32'h00020123, 2'd1, 1'b0, 2'd3, 32'h0},         // R5 no write
    '{32'h00020004, 2'd0, 1'b1, 2'd0, 32'h00300004},  // R2
    '{32'hC0000010, 2'd0, 1'b1, 2'd3, 32'h0},         // R6 user on supervisor page
    '{32'hC0000010, 2'd1, 1'b0, 2'd0, 32'h00400010},  // R6 supervisor allowed
    '{32'hC0000FFC, 2'd2, 1'b0, 2'd0, 32'h00400FFC},  // R6
    '{32'h00050000, 2'd0, 1'b0, 2'd2, 32'h0},         // R4
    '{32'h00050000, 2'd1, 1'b1, 2'd2, 32'h0},         // R4 beats protection
    '{32'h00060008, 2'd0, 1'b0, 2'd3, 32'h0},         // R5 no read
    '{32'h00060008, 2'd1, 1'b1, 2'd0, 32'h00600008},  // R5 write allowed
    '{32'h12345678, 2'd0, 1'b0, 2'd1, 32'h0},         // R3 miss
    '{32'h0000B000, 2'd0, 1'b0, 2'd1, 32'h0}          // R3 adjacent page
  };

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                         input logic [4:0] perm, input bit with_flush);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
    flush = with_flush;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] acc,
                        input logic usr, input logic [1:0] st,
                        input logic [31:0] pa, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = usr;
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check(rsp_status == st, {tag, " status"}, 64'(rsp_status), 64'(st));
    check(rsp_paddr == pa, {tag, " paddr"}, 64'(rsp_paddr), 64'(pa));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset, no mappings held
    check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    lookup(32'h0000A877, 2'd0, 1'b0, 2'd1, 32'h0, "R1 empty miss");

    // perm = {present, read, write, execute, user}
    do_fill(20'h0000A, 20'h000A5, 5'b11101, 1'b0);
    do_fill(20'h00020, 20'h00300, 5'b11011, 1'b0);
    do_fill(20'hC0000, 20'h00400, 5'b11110, 1'b0);
    do_fill(20'h00050, 20'h00500, 5'b01100, 1'b0);
    do_fill(20'h00060, 20'h00600, 5'b10101, 1'b0);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].va, VECS[i].acc, VECS[i].usr, VECS[i].st, VECS[i].pa,
             $sformatf("vec%0d", i));
    end

    // R7: back-pressure holds the response and blocks new requests
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1;
    req_vaddr = 32'h0000A877; req_acc = 2'd0; req_user = 1'b1;
    @(negedge clk);
    check(rsp_valid && rsp_paddr == 32'h000A5877, "R7 first rsp",
          64'(rsp_paddr), 64'h000A5877);
    check(req_ready == 1'b0, "R7 ready low", 64'(req_ready), 64'd0);
    req_vaddr = 32'h00020123; req_acc = 2'd2;
    @(negedge clk);
    check(rsp_valid && rsp_paddr == 32'h000A5877, "R7 held rsp",
          64'(rsp_paddr), 64'h000A5877);
    check(rsp_status == 2'd0, "R7 held status", 64'(rsp_status), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_paddr == 32'h00300123, "R7 second rsp",
          64'(rsp_paddr), 64'h00300123);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 drained", 64'(rsp_valid), 64'd0);

    // R8: refill of a held page overwrites its slot
    do_fill(20'h0000A, 20'h00777, 5'b11111, 1'b0);
    lookup(32'h0000A877, 2'd2, 1'b1, 2'd0, 32'h00777877, "R8 overwrite");

    // R10: flush empties everything
    do_flush();
    lookup(32'h00020123, 2'd2, 1'b1, 2'd1, 32'h0, "R10 flushed");
    lookup(32'h0000A877, 2'd0, 1'b0, 2'd1, 32'h0, "R10 flushed A");

    // R10: flush and fill together leave only the filled mapping
    do_fill(20'h0000A, 20'h000A5, 5'b11111, 1'b0);
    do_fill(20'h00070, 20'h00070, 5'b11111, 1'b1);
    lookup(32'h00070010, 2'd0, 1'b0, 2'd0, 32'h00070010, "R10 fill wins");
    lookup(32'h0000A010, 2'd0, 1'b0, 2'd1, 32'h0, "R10 old gone");

    // R9: fill remaining slots, then round-robin from slot 0
    for (int k = 1; k <= 7; k++) begin
      do_fill(20'h00100 + 20'(k), 20'h00200 + 20'(k), 5'b11111, 1'b0);
    end
    lookup(32'h00107004, 2'd0, 1'b0, 2'd0, 32'h00207004, "R9 full hit");
    do_fill(20'h00108, 20'h00208, 5'b11111, 1'b0);
    lookup(32'h00070010, 2'd0, 1'b0, 2'd1, 32'h0, "R9 slot0 evicted");
    lookup(32'h00101000, 2'd0, 1'b0, 2'd0, 32'h00201000, "R9 slot1 kept");
    lookup(32'h00108000, 2'd0, 1'b0, 2'd0, 32'h00208000, "R9 new present");
    do_fill(20'h00109, 20'h00209, 5'b11111, 1'b0);
    lookup(32'h00101000, 2'd0, 1'b0, 2'd1, 32'h0, "R9 slot1 evicted");
    lookup(32'h00102000, 2'd0, 1'b0, 2'd0, 32'h00202000, "R9 slot2 kept");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule